// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block follows a chain of transmit descriptors that software has placed in host memory for a single channel. Each descriptor is three 32-bit words at consecutive addresses: a parameter word, a pointer to the payload, and a pointer to the next descriptor. The block reads these words through a word-read master port and hands the payload location and size to a downstream byte fetcher over a valid/ready handshake. When a descriptor closes a frame, the block raises a one-cycle frame-indication request that carries the channel number.

The walk has two phases. In the first phase the block reads the parameter word at the current address. It takes the descriptor only when the ownership flag is clear, and each of these attempts is published to a shadow table of current-transmit addresses. In the second phase, after the descriptor has been handed on, the block keeps re-reading the same parameter word until the flag is clear again. It then moves to the next-descriptor pointer that it captured during the first phase. When a poll finds the flag set, the next read of that word waits for a programmable idle interval. A current pointer of zero parks the walker until a new pointer is loaded.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, and while the current pointer is zero, the block issues no memory request, offers no descriptor and raises no frame indication. A new pointer on `loadPtr` is taken only in this parked state.
- R2: Each phase-one parameter read is issued at the current descriptor address. In the cycle that read is granted, `ctaWe` pulses with `ctaAddr` equal to that address and `ctaChan` equal to `chanId`.
- R3: If the phase-one parameter word has bit 30 (ownership flag) set, the block reads neither of the other two words, offers nothing, and retries the same parameter word.
- R4: After a parameter response with bit 30 set, `rdReq` stays low for exactly `pollGap`+1 cycles before the same word is read again. With an always-granted port, consecutive requests are therefore `pollGap`+3 cycles apart.
- R5: When the flag is clear, the block reads the word at +4 (payload pointer) and then the word at +8 (next pointer). It then offers `descPtr` equal to the +4 word, `descLen` equal to parameter bits 28:16, and `descEnd` equal to parameter bit 31.
- R6: While `descValid` is high and `descReady` is low, the offered fields stay stable and no memory request is made.
- R7: The cycle right after a handshake on a descriptor whose bit 31 is set, `fiReq` pulses for one cycle with `fiChan` equal to `chanId`. No pulse follows a descriptor with bit 31 clear. A byte count of zero is offered unchanged.
- R8: Phase two re-reads only the same parameter word, with the R4 spacing, while bit 30 is set. Once the flag is clear, the next phase-one read starts at the captured +8 pointer.
- R9: When the captured next pointer is zero, the block parks after phase two and makes no further requests until a new pointer is loaded.
- R10: A memory request holds `rdReq` high with a stable `rdAddr` until `rdGnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanId | input | CHAN_W | Channel number used for indications and shadow writes |
| pollGap | input | GAP_W | Idle interval between polls of a held descriptor |
| loadValid | input | 1 | Load strobe for a new current pointer |
| loadPtr | input | 32 | Pointer value to load |
| rdReq | output | 1 | Memory read request |
| rdAddr | output | 32 | Byte address of the word to read |
| rdGnt | input | 1 | Memory accepts the request |
| rdValid | input | 1 | Read data returned |
| rdData | input | 32 | Read data word |
| descValid | output | 1 | Descriptor info offered |
| descReady | input | 1 | Byte fetcher accepts the descriptor info |
| descPtr | output | 32 | Payload pointer |
| descLen | output | 13 | Payload byte count |
| descEnd | output | 1 | Descriptor closes a frame |
| fiReq | output | 1 | Frame-indication request pulse |
| fiChan | output | CHAN_W | Channel carried by the indication |
| ctaWe | output | 1 | Shadow-table write strobe |
| ctaChan | output | CHAN_W | Shadow-table slot index |
| ctaAddr | output | 32 | Current descriptor address written to the slot |

## Verification
The shadow-table publish and the acceptance of the phase-one parameter read share a single cycle. The bench holds `rdGnt` low right after a load, so the request is waiting while the publish is still pending. It then judges that no publish happens before the grant and that the address written matches the front of the expected-descriptor queue. The other close pairing is the descriptor handshake and the frame indication in the next cycle. The monitor compares each handshake's frame-end flag with the presence of a pulse one cycle later, including a zero-length frame-end descriptor.

// File: rtl/tdw_pkg.sv
`timescale 1ns/1ps
package tdw_pkg;
  localparam int WORD_W  = 32;
  localparam int HOLD_BIT = 30;
  localparam int END_BIT  = 31;
  localparam int CNT_LSB  = 16;
  localparam int CNT_W    = 13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_A_REQ, ST_A_PRM, ST_A_DREQ, ST_A_DAT, ST_A_NREQ, ST_A_NXT,
    ST_OFFER, ST_FI, ST_B_REQ, ST_B_PRM, ST_GAP_A, ST_GAP_B
  } walkState_t;

  typedef enum logic [1:0] {
    OFF_PARAM = 2'd0,
    OFF_DATA  = 2'd1,
    OFF_NEXT  = 2'd2
  } wordSel_t;

  typedef struct packed {
    logic     ldCur;
    logic     ldParam;
    logic     ldData;
    logic     ldNext;
    logic     advance;
    logic     gapArm;
    logic     gapTick;
    wordSel_t sel;
  } walkStrb_t;
endpackage

// File: rtl/tdw_datapath.sv
`timescale 1ns/1ps
module tdw_datapath
  import tdw_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrb_t         strb,
  input  logic [WORD_W-1:0] loadPtr,
  input  logic [WORD_W-1:0] rdData,
  input  logic [GAP_W-1:0]  pollGap,
  output logic [WORD_W-1:0] curPtr,
  output logic [WORD_W-1:0] rdAddr,
  output logic [WORD_W-1:0] descPtr,
  output logic [CNT_W-1:0]  descLen,
  output logic              descEnd,
  output logic              holdNow,
  output logic              curZero,
  output logic              gapDone
);
  localparam int PAD_W = WORD_W - 4;

  logic [WORD_W-1:0] curQ, nextQ, dataQ;
  logic [CNT_W-1:0]  lenQ;
  logic              endQ;
  logic [GAP_W-1:0]  gapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ  <= '0;
      nextQ <= '0;
      dataQ <= '0;
      lenQ  <= '0;
      endQ  <= 1'b0;
      gapQ  <= '0;
    end else begin
      if (strb.ldCur)        curQ  <= loadPtr;
      else if (strb.advance) curQ  <= nextQ;
      if (strb.ldParam) begin
        lenQ <= rdData[CNT_LSB +: CNT_W];
        endQ <= rdData[END_BIT];
      end
      if (strb.ldData) dataQ <= rdData;
      if (strb.ldNext) nextQ <= rdData;
      if (strb.gapArm)                  gapQ <= pollGap;
      else if (strb.gapTick && gapQ != '0) gapQ <= gapQ - 1'b1;
    end
  end

  assign rdAddr  = curQ + {{PAD_W{1'b0}}, strb.sel, 2'b00};
  assign curPtr  = curQ;
  assign descPtr = dataQ;
  assign descLen = lenQ;
  assign descEnd = endQ;
  assign holdNow = rdData[HOLD_BIT];
  assign curZero = (curQ == '0);
  assign gapDone = (gapQ == '0);
endmodule

// File: rtl/tdw_control.sv
`timescale 1ns/1ps
module tdw_control
  import tdw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadValid,
  input  logic      curZero,
  input  logic      holdNow,
  input  logic      gapDone,
  input  logic      descEnd,
  input  logic      rdGnt,
  input  logic      rdValid,
  input  logic      descReady,
  output walkStrb_t strb,
  output logic      rdReq,
  output logic      descValid,
  output logic      fiReq,
  output logic      ctaWe
);
  walkState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt       = st;
    strb      = '0;
    strb.sel  = OFF_PARAM;
    rdReq     = 1'b0;
    descValid = 1'b0;
    fiReq     = 1'b0;
    ctaWe     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (loadValid)     strb.ldCur = 1'b1;
        else if (!curZero) nxt = ST_A_REQ;
      end
      ST_A_REQ: begin
        rdReq = 1'b1;
        ctaWe = rdGnt;
        if (rdGnt) nxt = ST_A_PRM;
      end
      ST_A_PRM: begin
        if (rdValid) begin
          if (holdNow) begin
            strb.gapArm = 1'b1;
            nxt = ST_GAP_A;
          end else begin
            strb.ldParam = 1'b1;
            nxt = ST_A_DREQ;
          end
        end
      end
      ST_A_DREQ: begin
        rdReq    = 1'b1;
        strb.sel = OFF_DATA;
        if (rdGnt) nxt = ST_A_DAT;
      end
      ST_A_DAT: begin
        if (rdValid) begin
          strb.ldData = 1'b1;
          nxt = ST_A_NREQ;
        end
      end
      ST_A_NREQ: begin
        rdReq    = 1'b1;
        strb.sel = OFF_NEXT;
        if (rdGnt) nxt = ST_A_NXT;
      end
      ST_A_NXT: begin
        if (rdValid) begin
          strb.ldNext = 1'b1;
          nxt = ST_OFFER;
        end
      end
      ST_OFFER: begin
        descValid = 1'b1;
        if (descReady) nxt = descEnd ? ST_FI : ST_B_REQ;
      end
      ST_FI: begin
        fiReq = 1'b1;
        nxt   = ST_B_REQ;
      end
      ST_B_REQ: begin
        rdReq = 1'b1;
        if (rdGnt) nxt = ST_B_PRM;
      end
      ST_B_PRM: begin
        if (rdValid) begin
          if (holdNow) begin
            strb.gapArm = 1'b1;
            nxt = ST_GAP_B;
          end else begin
            strb.advance = 1'b1;
            nxt = ST_IDLE;
          end
        end
      end
      ST_GAP_A: begin
        strb.gapTick = 1'b1;
        if (gapDone) nxt = ST_A_REQ;
      end
      ST_GAP_B: begin
        strb.gapTick = 1'b1;
        if (gapDone) nxt = ST_B_REQ;
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/tx_desc_walker.sv
`timescale 1ns/1ps
module tx_desc_walker
  import tdw_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] chanId,
  input  logic [GAP_W-1:0]  pollGap,
  input  logic              loadValid,
  input  logic [WORD_W-1:0] loadPtr,
  output logic              rdReq,
  output logic [WORD_W-1:0] rdAddr,
  input  logic              rdGnt,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdData,
  output logic              descValid,
  input  logic              descReady,
  output logic [WORD_W-1:0] descPtr,
  output logic [CNT_W-1:0]  descLen,
  output logic              descEnd,
  output logic              fiReq,
  output logic [CHAN_W-1:0] fiChan,
  output logic              ctaWe,
  output logic [CHAN_W-1:0] ctaChan,
  output logic [WORD_W-1:0] ctaAddr
);
  walkStrb_t         strb;
  logic              holdNow, curZero, gapDone;
  logic [WORD_W-1:0] curPtr;

  tdw_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .curZero   (curZero),
    .holdNow   (holdNow),
    .gapDone   (gapDone),
    .descEnd   (descEnd),
    .rdGnt     (rdGnt),
    .rdValid   (rdValid),
    .descReady (descReady),
    .strb      (strb),
    .rdReq     (rdReq),
    .descValid (descValid),
    .fiReq     (fiReq),
    .ctaWe     (ctaWe)
  );

  tdw_datapath #(.GAP_W(GAP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadPtr (loadPtr),
    .rdData  (rdData),
    .pollGap (pollGap),
    .curPtr  (curPtr),
    .rdAddr  (rdAddr),
    .descPtr (descPtr),
    .descLen (descLen),
    .descEnd (descEnd),
    .holdNow (holdNow),
    .curZero (curZero),
    .gapDone (gapDone)
  );

  assign fiChan  = chanId;
  assign ctaChan = chanId;
  assign ctaAddr = curPtr;
endmodule

// File: rtl/tdw_checker.sv
`timescale 1ns/1ps
module tdw_checker #(
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             rdGnt,
  input logic [31:0]      rdAddr,
  input logic             rdValid,
  input logic             rspHold,
  input logic             descValid,
  input logic             descReady,
  input logic [31:0]      descPtr,
  input logic [12:0]      descLen,
  input logic             descEnd,
  input logic             fiReq,
  input logic             ctaWe,
  input logic [31:0]      ctaAddr,
  input logic [GAP_W-1:0] pollGap
);
  logic [31:0] curSeen, lastAddr;
  logic        waitQ;
  logic [15:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSeen  <= '0;
      lastAddr <= '0;
      waitQ    <= 1'b0;
      idleCnt  <= '0;
    end else begin
      if (ctaWe) curSeen <= ctaAddr;
      if (rdReq && rdGnt) lastAddr <= rdAddr;
      if (rdReq) waitQ <= 1'b0;
      else if (rdValid && rspHold && lastAddr == curSeen) begin
        waitQ   <= 1'b1;
        idleCnt <= '0;
      end else if (idleCnt != 16'hFFFF) idleCnt <= idleCnt + 1'b1;
    end
  end

  // R2
  cta_on_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctaWe |-> (rdReq && rdGnt && rdAddr == ctaAddr));

  // R4
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && waitQ) |-> (idleCnt > {{(16-GAP_W){1'b0}}, pollGap}));

  // R6
  desc_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(descPtr) && $stable(descLen) && $stable(descEnd)));

  // R6
  no_read_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(descValid && rdReq));

  // R7
  fi_after_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiReq |-> $past(descValid && descReady && descEnd));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdGnt) |=> (rdReq && $stable(rdAddr)));
endmodule

bind tx_desc_walker tdw_checker #(.GAP_W(GAP_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdReq     (rdReq),
  .rdGnt     (rdGnt),
  .rdAddr    (rdAddr),
  .rdValid   (rdValid),
  .rspHold   (rdData[30]),
  .descValid (descValid),
  .descReady (descReady),
  .descPtr   (descPtr),
  .descLen   (descLen),
  .descEnd   (descEnd),
  .fiReq     (fiReq),
  .ctaWe     (ctaWe),
  .ctaAddr   (ctaAddr),
  .pollGap   (pollGap)
);

// File: tb/tx_desc_walker_bench.sv
`timescale 1ns/1ps
module tx_desc_walker_bench;
  localparam int P = 3;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] ptr;
    logic [12:0] len;
    logic        fe;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  chanId = 5'd9;
  logic [7:0]  pollGap = 8'(P);
  logic        loadValid = 1'b0;
  logic [31:0] loadPtr = '0;
  logic        rdReq, rdGnt, rdValid, descValid, descReady, descEnd, fiReq, ctaWe;
  logic [31:0] rdAddr, rdData, descPtr, ctaAddr;
  logic [12:0] descLen;
  logic [4:0]  fiChan, ctaChan;
  logic        gntOn = 1'b1;
  logic [31:0] mem [0:63];

  expItem_t expQ[$];
  int       expFi[$];
  int       checks = 0;
  int       errors = 0;
  logic     prevHs = 1'b0, prevEnd = 1'b0;

  always #2.5 clk = ~clk;
  assign rdGnt = gntOn;
  initial descReady = 1'b1;

  tx_desc_walker u_tx_desc_walker (
    .clk(clk), .rstN(rstN), .chanId(chanId), .pollGap(pollGap),
    .loadValid(loadValid), .loadPtr(loadPtr),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdGnt(rdGnt), .rdValid(rdValid), .rdData(rdData),
    .descValid(descValid), .descReady(descReady), .descPtr(descPtr),
    .descLen(descLen), .descEnd(descEnd), .fiReq(fiReq), .fiChan(fiChan),
    .ctaWe(ctaWe), .ctaChan(ctaChan), .ctaAddr(ctaAddr)
  );

  // memory model: one-cycle read latency
  initial rdValid = 1'b0;
  initial rdData = '0;
  always @(posedge clk) begin
    rdValid <= rdReq && rdGnt;
    if (rdReq && rdGnt) rdData <= mem[rdAddr[7:2]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pushDesc(input logic [31:0] a, input logic [31:0] ptr,
                          input logic [12:0] len, input logic fe,
                          input logic hold, input logic [31:0] nxt);
    expItem_t it;
    mem[a[7:2]]      = {fe, hold, 1'b0, len, 16'h0000};
    mem[a[7:2] + 6'd1] = ptr;
    mem[a[7:2] + 6'd2] = nxt;
    it.addr = a; it.ptr = ptr; it.len = len; it.fe = fe;
    expQ.push_back(it);
    if (fe) expFi.push_back(int'(chanId));
  endtask

  task automatic setHold(input logic [31:0] a, input logic v);
    mem[a[7:2]][30] = v;
  endtask

  // counts reads over n cycles; spacing of reads to address a
  task automatic watchReads(input logic [31:0] a, input int n,
                            output int same, output int other, output int bad);
    int prev;
    prev = -1; same = 0; other = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rdReq && rdGnt) begin
        if (rdAddr == a) begin
          if (prev >= 0 && (i - prev) != P + 3) bad++;
          prev = i;
          same++;
        end else other++;
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (descValid && descReady) begin
        if (expQ.size() == 0) chk(1'b0, "R5", "unexpected descriptor", descPtr, 32'h0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(descPtr == e.ptr, "R5", "descPtr", descPtr, e.ptr);
          chk(descLen == e.len, "R7", "descLen", 32'(descLen), 32'(e.len));
          chk(descEnd == e.fe, "R5", "descEnd", 32'(descEnd), 32'(e.fe));
        end
      end
      if (prevHs) chk(fiReq == prevEnd, "R7", "fiReq after handshake", 32'(fiReq), 32'(prevEnd));
      else if (fiReq) chk(1'b0, "R7", "fiReq without handshake", 32'(fiReq), 32'h0);
      if (fiReq) begin
        if (expFi.size() == 0) chk(1'b0, "R7", "unexpected fiReq", 32'(fiChan), 32'h0);
        else begin
          int c;
          c = expFi.pop_front();
          chk(int'(fiChan) == c, "R7", "fiChan", 32'(fiChan), 32'(c));
        end
      end
      if (ctaWe) begin
        chk(expQ.size() != 0 && ctaAddr == expQ[0].addr, "R2", "ctaAddr", ctaAddr,
            expQ.size() != 0 ? expQ[0].addr : 32'h0);
        chk(ctaChan == chanId && rdGnt, "R2", "ctaChan", 32'(ctaChan), 32'(chanId));
      end
      prevHs  = descValid && descReady;
      prevEnd = descEnd;
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int same, other, bad, bad6;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rdReq && !descValid && !fiReq && !ctaWe, "R1", "outputs after reset",
        {28'h0, rdReq, descValid, fiReq, ctaWe}, 32'h0);
    watchReads(32'hFFFF_FFFF, 12, same, other, bad);
    chk(other == 0, "R1", "reads while parked", 32'(other), 32'h0);

    pushDesc(32'h40, 32'h1000, 13'd5,  1'b0, 1'b0, 32'h50);
    pushDesc(32'h50, 32'h2000, 13'd0,  1'b1, 1'b0, 32'h60);
    pushDesc(32'h60, 32'h3000, 13'd12, 1'b1, 1'b1, 32'h70);
    pushDesc(32'h70, 32'h4000, 13'd3,  1'b1, 1'b0, 32'h00);

    // R10 grant stall
    tick(); gntOn = 1'b0; loadPtr = 32'h40; loadValid = 1'b1;
    tick(); loadValid = 1'b0;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0 && !(rdReq && rdAddr == 32'h40 && !ctaWe)) bad++;
    end
    chk(bad == 0, "R10", "request held while not granted", 32'(bad), 32'h0);
    tick(); gntOn = 1'b1;

    // wait for D0, D1 then phase-one polling of held D2
    while (expQ.size() > 2) @(negedge clk);
    do @(negedge clk); while (!(rdReq && rdGnt && rdAddr == 32'h60));
    watchReads(32'h60, 40, same, other, bad);
    chk(same >= 3, "R3", "held descriptor polled", 32'(same), 32'h3);
    chk(other == 0, "R3", "other words read while held", 32'(other), 32'h0);
    chk(bad == 0, "R4", "poll spacing", 32'(bad), 32'h0);
    chk(expQ.size() == 2, "R3", "no offer while held", 32'(expQ.size()), 32'h2);

    // R6 offer held under backpressure
    tick(); descReady = 1'b0; setHold(32'h60, 1'b0);
    do @(negedge clk); while (!descValid);
    bad6 = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!descValid || descPtr != 32'h3000 || descLen != 13'd12 || rdReq) bad6++;
    end
    chk(bad6 == 0, "R6", "stable offer without requests", 32'(bad6), 32'h0);

    // R8 phase two with ownership flag set again
    tick(); setHold(32'h60, 1'b1); descReady = 1'b1;
    watchReads(32'h60, 40, same, other, bad);
    chk(same >= 3, "R8", "phase-two polls", 32'(same), 32'h3);
    chk(other == 0, "R8", "no other reads in phase two", 32'(other), 32'h0);
    chk(bad == 0, "R8", "phase-two spacing", 32'(bad), 32'h0);
    chk(expQ.size() == 1, "R8", "next not offered yet", 32'(expQ.size()), 32'h1);
    tick(); setHold(32'h60, 1'b0);
    while (expQ.size() != 0 || expFi.size() != 0) @(negedge clk);

    // R9 stop on zero next pointer
    repeat (10) @(negedge clk);
    watchReads(32'hFFFF_FFFF, 30, same, other, bad);
    chk(other == 0, "R9", "reads after zero next pointer", 32'(other), 32'h0);

    // R1 reload after stop
    tick(); pushDesc(32'h70, 32'h4000, 13'd3, 1'b1, 1'b0, 32'h00);
    loadPtr = 32'h70; loadValid = 1'b1;
    tick(); loadValid = 1'b0;
    while (expQ.size() != 0 || expFi.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!rdReq && !descValid, "R9", "parked after reload walk",
        {30'h0, rdReq, descValid}, 32'h0);
    finishRun();
  end
endmodule